// File: doc/BRIEF.md
# Clock source switch controller

This block owns the oscillator control and status register of a chip and decides which of four clock-source groups drives the system clock. The four groups are primary, secondary, internal fast RC and internal low-power RC. Software writes the code of the group it wants into the request field and sets the go bit in the same write. The controller waits until the target source reports ready. If the target is the primary group and the primary sub-mode uses the PLL, it also waits for PLL lock. It then updates the current-group field and clears the go bit. Software can abort a pending switch by writing the go bit back to zero.

A clock monitor drives a failure input. When monitoring is enabled and that input is high, the block falls back to the fast RC group at the next clock edge. It sets a sticky fail flag and cancels any pending switch. A two-bit mode input selects one of three modes. In the first, switching and monitoring are both on. In the second, only switching is on. In the third, both are off and the selected source follows the configured default group directly. The glitch-free clock multiplexer and the oscillators themselves are outside this block. The block only produces the group code and the primary sub-mode that drive them.

States of the sequencer:
- IDLE waits for a set go bit.
- WAIT_SRC waits for the target's ready input.
- WAIT_LOCK waits for PLL lock.

Transitions:
- IDLE to WAIT_SRC is the start, taken on a valid request for a different group.
- IDLE stays in IDLE on a reject, which is a same-group or unknown code.
- WAIT_SRC to IDLE is a commit, taken when the target is ready and no lock is needed.
- WAIT_SRC to WAIT_LOCK is taken when the target is ready and lock is needed.
- WAIT_LOCK to IDLE is a commit, taken on lock.
- Any state goes to IDLE on a kill: abort, failure, or switching disabled.

Top module: `clksw_ctrl`

## Requirements
- R1: On reset (rst_n low), both the current-group field and the request field load `cfg_def_grp`. The go bit and the fail flag are 0.
- R2: The read value places the current group at bits 14:12, the request field at 10:8, the live `pll_lock` value at bit 5, the fail flag at bit 3 and the go bit at bit 0. A write with the go bit clear stores bits 10:8 in the request field.
- R3: The group codes are 000 fast RC, 010 secondary, 011 primary and 101 low-power RC. A write with bit 0 = 1 while the go bit is 0 sets the go bit at that edge. For a valid code that differs from the current group, and with the target ready, `src_sel` takes the new code on the second edge after the write, and the go bit clears on that same edge.
- R4: A request for any code not listed in R3, or for the current group, clears the go bit on the next edge and leaves `src_sel` unchanged.
- R5: A switch waits until the target's ready input is high. The ready indices are `src_rdy[0]` fast RC, `[1]` secondary, `[2]` primary and `[3]` low-power RC. The commit happens on the first edge at which the target's ready is sampled high.
- R6: When the target is primary and `cfg_pri_mode[4]` = 1, the switch also waits for `pll_lock`. The commit happens on the first edge at which lock is sampled high after ready was seen.
- R7: A write with bit 0 = 0 while the go bit is 1 clears the go bit on that edge and leaves the current group unchanged. A ready input that rises later has no effect.
- R8: While the go bit is 1, a write with bit 0 = 1 is ignored, and the request field keeps its value.
- R9: With `cfg_mon_mode` = 00 and `clk_fail` high at an edge, the current group becomes 000, the fail flag sets and the go bit clears. This takes priority over a commit in the same cycle. The fail flag stays set until reset.
- R10: With `cfg_mon_mode` = 01, `clk_fail` is ignored and switching works as in R3.
- R11: With `cfg_mon_mode` = 1x, `src_sel` equals `cfg_def_grp` combinationally, the go bit cannot be set and `clk_fail` is ignored.
- R12: `pri_sub` equals `cfg_pri_mode` while `src_sel` is 011 and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on/brown-out reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read value |
| cfg_def_grp | input | 3 | Configured default group |
| cfg_mon_mode | input | 2 | Monitor/switch mode: 00 both, 01 switch only, 1x none |
| cfg_pri_mode | input | 5 | Primary sub-mode; MSB selects the PLL |
| pll_lock | input | 1 | PLL lock status |
| src_rdy | input | 4 | Per-source ready inputs |
| clk_fail | input | 1 | Clock failure from the monitor |
| src_sel | output | 3 | Selected group code |
| pri_sub | output | 5 | Primary sub-mode for the selected source |

## Verification
A clock failure and a switch commit can land on the same edge. This happens when the target's ready input rises in the cycle the monitor flags a failure. The bench raises both inputs at the same falling edge while the sequencer sits in WAIT_SRC. After the next rising edge it expects the fast RC code, a set fail flag and a cleared go bit, and never the requested group. A second collision, between an abort write and a pending request, is judged by checking that a later ready input leaves the current group untouched.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
    localparam int REG_W    = 16;
    localparam int GRP_W    = 3;
    localparam int PRI_W    = 5;
    localparam int N_SRC    = 4;
    localparam int CUR_LSB  = 12;
    localparam int NEW_LSB  = 8;
    localparam int LOCK_BIT = 5;
    localparam int FAIL_BIT = 3;
    localparam int EN_BIT   = 0;

    localparam logic [GRP_W-1:0] GRP_FRC  = 3'b000;
    localparam logic [GRP_W-1:0] GRP_SEC  = 3'b010;
    localparam logic [GRP_W-1:0] GRP_PRI  = 3'b011;
    localparam logic [GRP_W-1:0] GRP_LPRC = 3'b101;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_SRC,
        ST_WAIT_LOCK
    } seq_st_e;

    function automatic logic grp_valid(input logic [GRP_W-1:0] g);
        return (g == GRP_FRC) || (g == GRP_SEC) || (g == GRP_PRI) || (g == GRP_LPRC);
    endfunction

    // group code belonging to ready input i
    function automatic logic [GRP_W-1:0] src_code(input int i);
        case (i)
            0:       return GRP_FRC;
            1:       return GRP_SEC;
            2:       return GRP_PRI;
            default: return GRP_LPRC;
        endcase
    endfunction
endpackage

// File: rtl/clksw_mode_dec.sv
module clksw_mode_dec (
    input  logic [1:0] mon_mode,
    input  logic       pll_bit,
    output logic       sw_on,
    output logic       mon_on,
    output logic       pll_use
);
    always_comb begin
        sw_on   = ~mon_mode[1];
        mon_on  = ~mon_mode[1] & ~mon_mode[0];
        pll_use = pll_bit;
    end
endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
    import clksw_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill,
    input  logic             en,
    input  logic [GRP_W-1:0] nosc,
    input  logic [GRP_W-1:0] cosc,
    input  logic [NS-1:0]    src_rdy,
    input  logic             pll_use,
    input  logic             pll_lock,
    output logic             commit,
    output logic             reject,
    output logic             busy
);
    seq_st_e st_q, st_d;
    logic [NS-1:0] hit;
    logic tgt_rdy, need_lock, go_ok;

    for (genvar g = 0; g < NS; g++) begin : g_hit
        assign hit[g] = src_rdy[g] && (nosc == src_code(g));
    end

    always_comb begin
        tgt_rdy   = |hit;
        need_lock = pll_use && (nosc == GRP_PRI);
        go_ok     = grp_valid(nosc) && (nosc != cosc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (en && !kill && go_ok) st_d = ST_WAIT_SRC;
            end
            ST_WAIT_SRC: begin
                if (kill)         st_d = ST_IDLE;
                else if (tgt_rdy) st_d = need_lock ? ST_WAIT_LOCK : ST_IDLE;
            end
            ST_WAIT_LOCK: begin
                if (kill || pll_lock) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        reject = 1'b0;
        busy   = (st_q != ST_IDLE);
        unique case (st_q)
            ST_IDLE:      reject = !kill && en && !go_ok;
            ST_WAIT_SRC:  commit = !kill && tgt_rdy && !need_lock;
            ST_WAIT_LOCK: commit = !kill && pll_lock;
            default: ;
        endcase
    end
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
#(
    parameter int PRI_WIDTH = PRI_W,
    parameter int NUM_SRC   = N_SRC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [GRP_W-1:0]     cfg_def_grp,
    input  logic [1:0]           cfg_mon_mode,
    input  logic [PRI_WIDTH-1:0] cfg_pri_mode,
    input  logic                 pll_lock,
    input  logic [NUM_SRC-1:0]   src_rdy,
    input  logic                 clk_fail,
    output logic [GRP_W-1:0]     src_sel,
    output logic [PRI_WIDTH-1:0] pri_sub
);
    logic [GRP_W-1:0] cosc_q, nosc_q, wr_new;
    logic en_q, cf_q;
    logic sw_on, mon_on, pll_use;
    logic fail_eff, abort, kill;
    logic commit, reject, busy;
    logic unused_bits;

    clksw_mode_dec mode_i (
        .mon_mode (cfg_mon_mode),
        .pll_bit  (cfg_pri_mode[PRI_WIDTH-1]),
        .sw_on    (sw_on),
        .mon_on   (mon_on),
        .pll_use  (pll_use)
    );

    clksw_seq #(.NS(NUM_SRC)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .kill     (kill),
        .en       (en_q),
        .nosc     (nosc_q),
        .cosc     (cosc_q),
        .src_rdy  (src_rdy),
        .pll_use  (pll_use),
        .pll_lock (pll_lock),
        .commit   (commit),
        .reject   (reject),
        .busy     (busy)
    );

    always_comb begin
        wr_new      = reg_wdata[NEW_LSB +: GRP_W];
        fail_eff    = mon_on && clk_fail;
        abort       = reg_wr && en_q && !reg_wdata[EN_BIT];
        kill        = !sw_on || fail_eff || abort;
        unused_bits = ^{reg_wdata[REG_W-1:NEW_LSB+GRP_W],
                        reg_wdata[NEW_LSB-1:EN_BIT+1], busy};
    end

    // register fields; priority: reset, disabled, failure, abort, commit, reject, write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cosc_q <= cfg_def_grp;
            nosc_q <= cfg_def_grp;
            en_q   <= 1'b0;
            cf_q   <= 1'b0;
        end else if (!sw_on) begin
            cosc_q <= cfg_def_grp;
            en_q   <= 1'b0;
            if (reg_wr) nosc_q <= wr_new;
        end else if (fail_eff) begin
            cosc_q <= GRP_FRC;
            cf_q   <= 1'b1;
            en_q   <= 1'b0;
        end else if (abort) begin
            en_q   <= 1'b0;
        end else if (commit) begin
            cosc_q <= nosc_q;
            en_q   <= 1'b0;
        end else if (reject) begin
            en_q   <= 1'b0;
        end else if (reg_wr && !en_q) begin
            nosc_q <= wr_new;
            en_q   <= reg_wdata[EN_BIT];
        end
    end

    always_comb begin
        src_sel   = sw_on ? cosc_q : cfg_def_grp;
        pri_sub   = (src_sel == GRP_PRI) ? cfg_pri_mode : '0;
        reg_rdata = '0;
        reg_rdata[CUR_LSB +: GRP_W] = src_sel;
        reg_rdata[NEW_LSB +: GRP_W] = nosc_q;
        reg_rdata[LOCK_BIT]         = pll_lock;
        reg_rdata[FAIL_BIT]         = cf_q;
        reg_rdata[EN_BIT]           = en_q;
    end
endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] reg_rdata,
    input logic [1:0]  cfg_mon_mode,
    input logic        clk_fail,
    input logic [2:0]  src_sel
);
    AST_RST_CLEAN: assert property (@(posedge clk)
        $rose(rst_n) |-> (!reg_rdata[0] && !reg_rdata[3])); // R1

    AST_SEL_VALID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(src_sel) && !cfg_mon_mode[1] && !$past(cfg_mon_mode[1]))
        |-> (src_sel == 3'b000 || src_sel == 3'b010 || src_sel == 3'b011 || src_sel == 3'b101)); // R3

    AST_GO_CLEAR_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(src_sel) && !cfg_mon_mode[1] && !$past(cfg_mon_mode[1]))
        |-> !reg_rdata[0]); // R3

    AST_FAIL_TO_FRC: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_fail && cfg_mon_mode == 2'b00)
        |=> (reg_rdata[3] && !reg_rdata[0] && (cfg_mon_mode[1] || src_sel == 3'b000))); // R9

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3] |=> reg_rdata[3]); // R9

    AST_DIS_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mon_mode[1] && $past(cfg_mon_mode[1])) |-> !reg_rdata[0]); // R11
endmodule

bind clksw_ctrl clksw_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_rdata    (reg_rdata),
    .cfg_mon_mode (cfg_mon_mode),
    .clk_fail     (clk_fail),
    .src_sel      (src_sel)
);

// File: tb/clksw_ctrl_tb_top.sv
module clksw_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  cfg_def_grp = 3'b000;
    logic [1:0]  cfg_mon_mode = 2'b00;
    logic [4:0]  cfg_pri_mode = 5'b00011;
    logic        pll_lock = 1'b0;
    logic [3:0]  src_rdy = 4'hF;
    logic        clk_fail = 1'b0;
    logic [2:0]  src_sel;
    logic [4:0]  pri_sub;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    localparam logic [2:0] VG [4] = '{3'b000, 3'b010, 3'b011, 3'b101};

    always #(CLK_PERIOD/2) clk = ~clk;

    clksw_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cfg_def_grp(cfg_def_grp), .cfg_mon_mode(cfg_mon_mode),
        .cfg_pri_mode(cfg_pri_mode), .pll_lock(pll_lock), .src_rdy(src_rdy),
        .clk_fail(clk_fail), .src_sel(src_sel), .pri_sub(pri_sub)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_dut(input logic [2:0] def);
        cfg_def_grp = def;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic wr(input logic [2:0] grp, input logic go);
        reg_wr = 1'b1;
        reg_wdata = {5'b0, grp, 7'b0, go};
        step(1);
        reg_wr = 1'b0;
    endtask

    function automatic logic is_valid(input logic [2:0] g);
        return g == 3'b000 || g == 3'b010 || g == 3'b011 || g == 3'b101;
    endfunction

    initial begin
        step(1);
        // R1 reset state
        cfg_def_grp = 3'b011;
        rst_n = 1'b0;
        step(1);
        check("R1 cur field in reset", int'(reg_rdata[14:12]), 3);
        check("R1 new field in reset", int'(reg_rdata[10:8]), 3);
        check("R1 go/fail in reset", int'({reg_rdata[3], reg_rdata[0]}), 0);
        rst_n = 1'b1;
        step(1);

        // R3 R4 R2 sweep: every valid start group against every code
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 8; t++) begin
                logic [2:0] exp_g;
                reset_dut(VG[f]);
                src_rdy = 4'hF;
                wr(3'(t), 1'b1);
                check("R3 go bit set by write", int'(reg_rdata[0]), 1);
                check("R2 new field written", int'(reg_rdata[10:8]), t);
                step(2);
                exp_g = (is_valid(3'(t)) && 3'(t) != VG[f]) ? 3'(t) : VG[f];
                check(is_valid(3'(t)) && 3'(t) != VG[f] ? "R3 switch result" : "R4 ignored request",
                      int'(src_sel), int'(exp_g));
                check("R3 go bit cleared", int'(reg_rdata[0]), 0);
                check("R2 cur field matches src_sel", int'(reg_rdata[14:12]), int'(exp_g));
            end
        end

        // R12 non-primary
        reset_dut(3'b000);
        check("R12 pri_sub zero off primary", int'(pri_sub), 0);

        // R5 wait for ready
        reset_dut(3'b000);
        src_rdy = 4'b0001;
        wr(3'b010, 1'b1);
        step(4);
        check("R5 holds without ready", int'(src_sel), 0);
        check("R5 go still set", int'(reg_rdata[0]), 1);
        src_rdy = 4'b0011;
        step(1);
        check("R5 commit on ready", int'(src_sel), 2);
        check("R5 go cleared", int'(reg_rdata[0]), 0);

        // R6 PLL lock wait
        cfg_pri_mode = 5'b10011;
        pll_lock = 1'b0;
        reset_dut(3'b000);
        src_rdy = 4'hF;
        wr(3'b011, 1'b1);
        step(4);
        check("R6 holds without lock", int'(src_sel), 0);
        check("R2 lock bit low", int'(reg_rdata[5]), 0);
        pll_lock = 1'b1;
        step(1);
        check("R6 commit on lock", int'(src_sel), 3);
        check("R2 lock bit high", int'(reg_rdata[5]), 1);
        check("R12 pri_sub on primary", int'(pri_sub), 5'b10011);
        pll_lock = 1'b0;
        cfg_pri_mode = 5'b00011;

        // R7 abort
        reset_dut(3'b000);
        src_rdy = 4'b0001;
        wr(3'b101, 1'b1);
        step(2);
        wr(3'b101, 1'b0);
        check("R7 go cleared by abort", int'(reg_rdata[0]), 0);
        src_rdy = 4'hF;
        step(3);
        check("R7 no switch after abort", int'(src_sel), 0);

        // R8 write during pending switch
        reset_dut(3'b000);
        src_rdy = 4'b0001;
        wr(3'b010, 1'b1);
        step(1);
        wr(3'b101, 1'b1);
        check("R8 new field kept", int'(reg_rdata[10:8]), 2);
        check("R8 go still set", int'(reg_rdata[0]), 1);
        src_rdy = 4'hF;
        step(1);
        check("R8 original target committed", int'(src_sel), 2);

        // R9 failure
        cfg_mon_mode = 2'b00;
        reset_dut(3'b010);
        clk_fail = 1'b1;
        step(1);
        clk_fail = 1'b0;
        check("R9 fallback to fast RC", int'(src_sel), 0);
        check("R9 fail flag", int'(reg_rdata[3]), 1);
        step(3);
        check("R9 fail flag sticky", int'(reg_rdata[3]), 1);

        // R9 failure colliding with commit
        reset_dut(3'b000);
        src_rdy = 4'b0001;
        wr(3'b010, 1'b1);
        step(2);
        src_rdy = 4'hF;
        clk_fail = 1'b1;
        step(1);
        clk_fail = 1'b0;
        check("R9 failure beats commit", int'(src_sel), 0);
        check("R9 fail flag on collision", int'(reg_rdata[3]), 1);
        check("R9 go cleared on collision", int'(reg_rdata[0]), 0);
        step(2);
        check("R9 no late commit", int'(src_sel), 0);

        // R10 monitor off
        cfg_mon_mode = 2'b01;
        reset_dut(3'b010);
        clk_fail = 1'b1;
        step(1);
        clk_fail = 1'b0;
        check("R10 failure ignored", int'(src_sel), 2);
        check("R10 no fail flag", int'(reg_rdata[3]), 0);
        wr(3'b101, 1'b1);
        step(2);
        check("R10 switching works", int'(src_sel), 5);

        // R11 all disabled
        cfg_mon_mode = 2'b10;
        reset_dut(3'b011);
        wr(3'b010, 1'b1);
        check("R11 go cannot set", int'(reg_rdata[0]), 0);
        step(2);
        check("R11 no switch", int'(src_sel), 3);
        cfg_def_grp = 3'b101;
        #1;
        check("R11 follows config", int'(src_sel), 5);
        clk_fail = 1'b1;
        step(1);
        clk_fail = 1'b0;
        step(1);
        check("R11 failure ignored", int'(src_sel), 5);
        check("R11 no fail flag", int'(reg_rdata[3]), 0);

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule